// File: doc/BRIEF.md
# Bus-Master ATA DMA Control and Status Registers

This block is the host-facing register set of a bus-mastering ATA DMA engine. Software programs a transfer through three registers: a control byte that starts or halts the engine and picks the transfer direction, a status byte, and a 32-bit pointer to the descriptor table in system memory. The transfer engine itself (descriptor walking, memory fetches, the drive interface) sits outside the block. It appears here only as three inputs that report the engine's running state and raise error and completion events.

The status byte combines three kinds of bits. The running bit is read-only and mirrors the engine. The error and interrupt bits are sticky event flags that software clears by writing one to them. Two per-drive "DMA capable" bits are plain read/write storage. The interrupt output is a level that stays high while the interrupt flag is set. A separate output flags the clean-completion pattern (interrupt set, no error, engine idle), which software tests at the end of a transfer.

The register bus is word-addressed with byte enables. Word 0 holds the control byte in lane 0 and the status byte in lane 2. Word 1 holds the table pointer. Words 2 and 3 are unmapped. Writes take effect at the clock edge, and reads are combinational from the stored state.

Top module: `bmdma_regs`

## Requirements
- R1: After an asynchronous reset (rst_ni low), every register reads 0, and eng_start_o, eng_to_mem_o, irq_o, xfer_ok_o and eng_table_base_o are 0.
- R2: A write to word 0 with lane 0 enabled loads control bit 0 (run) into eng_start_o and control bit 3 (1 = engine writes to memory) into eng_to_mem_o from the next cycle. Both bits read back at word 0 bits 0 and 3.
- R3: Status bit 0 (word 0 bit 16) is read-only and shows, one cycle later, the value of eng_active_i ANDed with the run bit. Host writes to it have no effect.
- R4: A write of 0 to control bit 0 while the engine is active clears status bit 0 in the following cycle and does not set the interrupt flag.
- R5: A one-cycle pulse on eng_err_set_i sets status bit 1 (word 0 bit 17). Writing 1 to that bit clears it, and writing 0 leaves it unchanged.
- R6: A pulse on eng_irq_set_i sets status bit 2 (word 0 bit 18). Writing 1 to that bit clears it. If a set pulse and a clearing write happen in the same cycle, the set wins.
- R7: irq_o is high exactly while status bit 2 is set. It falls only after a write that clears that bit.
- R8: Status bits 5 and 6 (word 0 bits 21 and 22) are read/write capability flags for drive 0 and drive 1. All other undefined bits of word 0 read 0.
- R9: Word 1 is a 32-bit read/write table pointer, written per byte lane under the byte enables and driven on eng_table_base_o.
- R10: xfer_ok_o is high exactly when status bits [2:0] equal 100b.
- R11: Lanes whose byte enable is low are not written. Writes to words 2 and 3 change nothing, and those words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Word address |
| reg_be_i | input | DATA_W/8 | Byte enables for a write |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for reg_addr_i |
| eng_active_i | input | 1 | Engine reports a transfer in progress |
| eng_err_set_i | input | 1 | Engine error event pulse |
| eng_irq_set_i | input | 1 | Engine completion or interrupt event pulse |
| eng_start_o | output | 1 | Run command to the engine |
| eng_to_mem_o | output | 1 | Direction: 1 = engine writes memory |
| eng_table_base_o | output | TBL_W | Descriptor table base address |
| irq_o | output | 1 | Level interrupt |
| xfer_ok_o | output | 1 | Clean-completion pattern present |

## Verification
The assertions check several behaviours on every cycle. The running bit never rises unless the engine was active the cycle before. A halt write always clears the running bit without raising the interrupt. Event pulses always land in their flags, and the set pulse wins over a clear. A flag only drops after a write of one, and the interrupt line only falls after such a write. Other behaviours only the bench's scenarios can show: the exact read-back layout of word 0, the effect of byte enables on each lane, the assembly of the table pointer from partial writes, that unmapped words ignore writes, and the reset values.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  // word map
  localparam int unsigned WORD_CTRL = 0;
  localparam int unsigned WORD_TBL  = 1;
  // byte lanes inside the control word
  localparam int unsigned LANE_CMD  = 0;
  localparam int unsigned LANE_STAT = 2;
  // control byte fields
  localparam int unsigned CMD_RUN   = 0;
  localparam int unsigned CMD_DIR   = 3;
  // status byte fields
  localparam int unsigned ST_ACT    = 0;
  localparam int unsigned ST_ERR    = 1;
  localparam int unsigned ST_IRQ    = 2;
  localparam int unsigned ST_CAP0   = 5;
  localparam int unsigned ST_CAP1   = 6;

  typedef struct packed {
    logic       act;
    logic       err;
    logic       irq;
    logic [1:0] cap;
  } stat_t;

  function automatic logic [7:0] pack_stat(stat_t s);
    logic [7:0] b;
    b = '0;
    b[ST_ACT]  = s.act;
    b[ST_ERR]  = s.err;
    b[ST_IRQ]  = s.irq;
    b[ST_CAP0] = s.cap[0];
    b[ST_CAP1] = s.cap[1];
    return b;
  endfunction
endpackage

// File: rtl/bmdma_cmd_reg.sv
module bmdma_cmd_reg (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       run_wd_i,
  input  logic       dir_wd_i,
  output logic       run_o,
  output logic       run_next_o,
  output logic       dir_o,
  output logic [7:0] cmd_byte_o
);
  import bmdma_pkg::*;

  logic run_q, dir_q;

  assign run_next_o = wr_i ? run_wd_i : run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      dir_q <= 1'b0;
    end else if (wr_i) begin
      run_q <= run_wd_i;
      dir_q <= dir_wd_i;
    end
  end

  always_comb begin
    cmd_byte_o          = '0;
    cmd_byte_o[CMD_RUN] = run_q;
    cmd_byte_o[CMD_DIR] = dir_q;
  end

  assign run_o = run_q;
  assign dir_o = dir_q;
endmodule

// File: rtl/bmdma_stat_reg.sv
module bmdma_stat_reg (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       err_w1c_i,
  input  logic       irq_w1c_i,
  input  logic [1:0] cap_wd_i,
  input  logic       run_next_i,
  input  logic       eng_active_i,
  input  logic       eng_err_set_i,
  input  logic       eng_irq_set_i,
  output logic [7:0] stat_byte_o,
  output logic       irq_o,
  output logic       ok_o
);
  import bmdma_pkg::*;

  stat_t st_q, st_d;

  always_comb begin
    st_d     = st_q;
    // running bit: engine state gated by the run command after this cycle's write
    st_d.act = eng_active_i & run_next_i;
    // event flags: set has priority over write-one-to-clear
    st_d.err = eng_err_set_i | (st_q.err & ~(wr_i & err_w1c_i));
    st_d.irq = eng_irq_set_i | (st_q.irq & ~(wr_i & irq_w1c_i));
    if (wr_i) st_d.cap = cap_wd_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= st_d;
  end

  assign stat_byte_o = pack_stat(st_q);
  assign irq_o       = st_q.irq;
  assign ok_o        = st_q.irq & ~st_q.err & ~st_q.act;
endmodule

// File: rtl/bmdma_tbl_reg.sv
module bmdma_tbl_reg #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TBL_W  = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [DATA_W/8-1:0] be_i,
  input  logic [TBL_W-1:0]    wdata_i,
  output logic [TBL_W-1:0]    tbl_o
);
  localparam int unsigned TBL_LANES = TBL_W / 8;

  for (genvar l = 0; l < TBL_LANES; l++) begin : g_lane
    logic [7:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             byte_q <= '0;
      else if (wr_i && be_i[l]) byte_q <= wdata_i[l*8 +: 8];
    end
    assign tbl_o[l*8 +: 8] = byte_q;
  end

  if (TBL_LANES < DATA_W / 8) begin : g_be_spare
    logic unused_be;
    assign unused_be = ^be_i[DATA_W/8-1:TBL_LANES];
  end
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned TBL_W  = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_we_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [DATA_W/8-1:0] reg_be_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  input  logic                eng_active_i,
  input  logic                eng_err_set_i,
  input  logic                eng_irq_set_i,
  output logic                eng_start_o,
  output logic                eng_to_mem_o,
  output logic [TBL_W-1:0]    eng_table_base_o,
  output logic                irq_o,
  output logic                xfer_ok_o
);
  import bmdma_pkg::*;

  logic       sel_ctrl, sel_tbl;
  logic       wr_cmd, wr_stat, wr_tbl;
  logic [7:0] cmd_wd, stat_wd;
  logic [7:0] cmd_byte, stat_byte;
  logic       run_next;

  assign sel_ctrl = (reg_addr_i == ADDR_W'(WORD_CTRL));
  assign sel_tbl  = (reg_addr_i == ADDR_W'(WORD_TBL));
  assign wr_cmd   = reg_we_i & sel_ctrl & reg_be_i[LANE_CMD];
  assign wr_stat  = reg_we_i & sel_ctrl & reg_be_i[LANE_STAT];
  assign wr_tbl   = reg_we_i & sel_tbl;
  assign cmd_wd   = reg_wdata_i[LANE_CMD*8 +: 8];
  assign stat_wd  = reg_wdata_i[LANE_STAT*8 +: 8];

  bmdma_cmd_reg u_cmd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_cmd),
    .run_wd_i   (cmd_wd[CMD_RUN]),
    .dir_wd_i   (cmd_wd[CMD_DIR]),
    .run_o      (eng_start_o),
    .run_next_o (run_next),
    .dir_o      (eng_to_mem_o),
    .cmd_byte_o (cmd_byte)
  );

  bmdma_stat_reg u_stat (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_i          (wr_stat),
    .err_w1c_i     (stat_wd[ST_ERR]),
    .irq_w1c_i     (stat_wd[ST_IRQ]),
    .cap_wd_i      ({stat_wd[ST_CAP1], stat_wd[ST_CAP0]}),
    .run_next_i    (run_next),
    .eng_active_i  (eng_active_i),
    .eng_err_set_i (eng_err_set_i),
    .eng_irq_set_i (eng_irq_set_i),
    .stat_byte_o   (stat_byte),
    .irq_o         (irq_o),
    .ok_o          (xfer_ok_o)
  );

  bmdma_tbl_reg #(
    .DATA_W (DATA_W),
    .TBL_W  (TBL_W)
  ) u_tbl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_tbl),
    .be_i    (reg_be_i),
    .wdata_i (reg_wdata_i[TBL_W-1:0]),
    .tbl_o   (eng_table_base_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (sel_ctrl) begin
      reg_rdata_o[LANE_CMD*8 +: 8]  = cmd_byte;
      reg_rdata_o[LANE_STAT*8 +: 8] = stat_byte;
    end else if (sel_tbl) begin
      reg_rdata_o[TBL_W-1:0] = eng_table_base_o;
    end
  end

  logic unused_wd;
  assign unused_wd = ^{cmd_wd[7:4], cmd_wd[2:1], stat_wd[7], stat_wd[4:3], stat_wd[0]};
endmodule

// File: rtl/bmdma_regs_chk.sv
module bmdma_regs_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_cmd,
  input logic       wr_stat,
  input logic [7:0] cmd_wd,
  input logic [7:0] stat_wd,
  input logic [7:0] stat_byte,
  input logic       eng_active_i,
  input logic       eng_err_set_i,
  input logic       eng_irq_set_i,
  input logic       eng_start_o,
  input logic       irq_o,
  input logic       xfer_ok_o
);
  import bmdma_pkg::*;

  p_start_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cmd |=> (eng_start_o == $past(cmd_wd[CMD_RUN])));

  p_act_source_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_byte[ST_ACT]) |-> $past(eng_active_i));

  p_halt_clears_act_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cmd && !cmd_wd[CMD_RUN]) |=> !stat_byte[ST_ACT]);

  p_halt_no_irq_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cmd && !cmd_wd[CMD_RUN] && !eng_irq_set_i && !irq_o) |=> !irq_o);

  p_err_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_err_set_i |=> stat_byte[ST_ERR]);

  p_err_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_byte[ST_ERR] && !(wr_stat && stat_wd[ST_ERR])) |=> stat_byte[ST_ERR]);

  p_irq_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_irq_set_i |=> irq_o);

  p_irq_w1c_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && stat_wd[ST_IRQ] && !eng_irq_set_i) |=> !stat_byte[ST_IRQ]);

  p_irq_fall_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(wr_stat && stat_wd[ST_IRQ]));

  p_ok_pattern_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_ok_o |-> (irq_o && !stat_byte[ST_ERR] && !stat_byte[ST_ACT]));
endmodule

bind bmdma_regs bmdma_regs_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_cmd        (wr_cmd),
  .wr_stat       (wr_stat),
  .cmd_wd        (cmd_wd),
  .stat_wd       (stat_wd),
  .stat_byte     (stat_byte),
  .eng_active_i  (eng_active_i),
  .eng_err_set_i (eng_err_set_i),
  .eng_irq_set_i (eng_irq_set_i),
  .eng_start_o   (eng_start_o),
  .irq_o         (irq_o),
  .xfer_ok_o     (xfer_ok_o)
);

// File: tb/bmdma_regs_tb.sv
module bmdma_regs_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [3:0]  reg_be_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        eng_active_i = 1'b0;
  logic        eng_err_set_i = 1'b0;
  logic        eng_irq_set_i = 1'b0;
  logic        eng_start_o, eng_to_mem_o, irq_o, xfer_ok_o;
  logic [31:0] eng_table_base_o;

  int checks = 0;
  int fails  = 0;

  always #10 clk_i = ~clk_i;

  bmdma_regs dut_i (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_be_i, .reg_wdata_i,
    .reg_rdata_o, .eng_active_i, .eng_err_set_i, .eng_irq_set_i,
    .eng_start_o, .eng_to_mem_o, .eng_table_base_o, .irq_o, .xfer_ok_o
  );

  // {we, addr, be, wdata, act, err_set, irq_set, expected word 0}
  localparam int NV = 14;
  localparam logic [73:0] VEC [NV] = '{
    {1'b1, 2'd0, 4'b0001, 32'h0000_0009, 3'b000, 32'h0000_0009}, // R2 run+dir
    {1'b0, 2'd0, 4'b0000, 32'h0000_0000, 3'b100, 32'h0001_0009}, // R3 active
    {1'b1, 2'd0, 4'b0100, 32'h0000_0000, 3'b100, 32'h0001_0009}, // R3 write ignored
    {1'b0, 2'd0, 4'b0000, 32'h0000_0000, 3'b001, 32'h0004_0009}, // R6 irq set
    {1'b0, 2'd0, 4'b0000, 32'h0000_0000, 3'b010, 32'h0006_0009}, // R5 err set
    {1'b1, 2'd0, 4'b0100, 32'h0002_0000, 3'b000, 32'h0004_0009}, // R5 w1c err
    {1'b1, 2'd0, 4'b0100, 32'h0064_0000, 3'b000, 32'h0060_0009}, // R8 caps, irq clr
    {1'b1, 2'd0, 4'b0100, 32'h0024_0000, 3'b001, 32'h0024_0009}, // R6 set wins
    {1'b1, 2'd0, 4'b0001, 32'h0000_0008, 3'b100, 32'h0024_0008}, // R4 halt
    {1'b1, 2'd0, 4'b0100, 32'h0004_0001, 3'b000, 32'h0000_0008}, // R11 lane0 off
    {1'b1, 2'd1, 4'b1111, 32'h1234_5678, 3'b000, 32'h0000_0008}, // R9 full write
    {1'b1, 2'd1, 4'b0010, 32'hAAAA_BBCC, 3'b000, 32'h0000_0008}, // R9 one lane
    {1'b1, 2'd0, 4'b0001, 32'h0000_0001, 3'b100, 32'h0001_0001}, // R2 restart
    {1'b1, 2'd0, 4'b0001, 32'h0000_0000, 3'b100, 32'h0000_0000}  // R4 halt again
  };

  function automatic string vtag(int i);
    case (i)
      0, 12:  return "R2";
      1, 2:   return "R3";
      3, 7:   return "R6";
      4, 5:   return "R5";
      6:      return "R8";
      8, 13:  return "R4";
      9:      return "R11";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic [1:0] a, input logic [3:0] be,
                     input logic [31:0] wd, input logic act, input logic es, input logic is);
    @(negedge clk_i);
    reg_we_i = we; reg_addr_i = a; reg_be_i = be; reg_wdata_i = wd;
    eng_active_i = act; eng_err_set_i = es; eng_irq_set_i = is;
    @(posedge clk_i);
    #2;
    reg_we_i = 1'b0; reg_addr_i = 2'd0; reg_be_i = '0;
    eng_err_set_i = 1'b0; eng_irq_set_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] e;
    #35;
    // R1 reset state
    rd(2'd0, d); chk(d == 32'h0, "R1", d, 32'h0);
    rd(2'd1, d); chk(d == 32'h0, "R1", d, 32'h0);
    chk({eng_start_o, eng_to_mem_o, irq_o, xfer_ok_o} == 4'b0, "R1",
        {28'h0, eng_start_o, eng_to_mem_o, irq_o, xfer_ok_o}, 32'h0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [73:0] v;
      v = VEC[i];
      cyc(v[73], v[72:71], v[70:67], v[66:35], v[34], v[33], v[32]);
      e = v[31:0];
      rd(2'd0, d);
      chk(d == e, vtag(i), d, e);
      chk(irq_o == e[18], "R7", {31'h0, irq_o}, {31'h0, e[18]});
      chk(eng_start_o == e[0] && eng_to_mem_o == e[3], "R2",
          {30'h0, eng_to_mem_o, eng_start_o}, {30'h0, e[3], e[0]});
      chk(xfer_ok_o == (e[18:16] == 3'b100), "R10",
          {31'h0, xfer_ok_o}, {31'h0, e[18:16] == 3'b100});
    end

    // R9 pointer assembled from partial writes
    rd(2'd1, d); chk(d == 32'h1234_BB78, "R9", d, 32'h1234_BB78);
    chk(eng_table_base_o == 32'h1234_BB78, "R9", eng_table_base_o, 32'h1234_BB78);

    // R11 unmapped words
    cyc(1'b1, 2'd2, 4'b1111, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0);
    cyc(1'b1, 2'd3, 4'b1111, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0);
    rd(2'd2, d); chk(d == 32'h0, "R11", d, 32'h0);
    rd(2'd3, d); chk(d == 32'h0, "R11", d, 32'h0);
    rd(2'd0, d); chk(d == 32'h0, "R11", d, 32'h0);
    rd(2'd1, d); chk(d == 32'h1234_BB78, "R11", d, 32'h1234_BB78);

    // R10 completion pattern variants
    cyc(1'b1, 2'd0, 4'b0001, 32'h1, 1'b1, 1'b0, 1'b0);
    cyc(1'b0, 2'd0, 4'b0000, 32'h0, 1'b1, 1'b0, 1'b1);
    rd(2'd0, d); chk(d == 32'h0005_0001 && !xfer_ok_o, "R10", d, 32'h0005_0001);
    cyc(1'b0, 2'd0, 4'b0000, 32'h0, 1'b0, 1'b0, 1'b0);
    rd(2'd0, d); chk(d == 32'h0004_0001 && xfer_ok_o, "R10", d, 32'h0004_0001);
    cyc(1'b0, 2'd0, 4'b0000, 32'h0, 1'b0, 1'b1, 1'b0);
    rd(2'd0, d); chk(d == 32'h0006_0001 && !xfer_ok_o, "R10", d, 32'h0006_0001);
    // R7 writing 0 to the irq flag keeps the line up
    cyc(1'b1, 2'd0, 4'b0100, 32'h0002_0000, 1'b0, 1'b0, 1'b0);
    chk(irq_o == 1'b1, "R7", {31'h0, irq_o}, 32'h1);

    // R1 asynchronous reset mid-run
    @(negedge clk_i);
    #3 rst_ni = 1'b0;
    #1;
    rd(2'd0, d); chk(d == 32'h0 && !irq_o && !eng_start_o, "R1", d, 32'h0);
    rd(2'd1, d); chk(d == 32'h0 && eng_table_base_o == 32'h0, "R1", d, 32'h0);
    #20 rst_ni = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule